// File: doc/BRIEF.md
# Radix-2 Frequency-Decimating Butterfly

This block is the arithmetic core of one stage of a streaming FFT that splits its input in frequency. On every clock where `en` is high it takes two packed complex samples and one packed complex twiddle factor. It produces two results. The first is the sum of the samples. The second is their difference rotated by the twiddle. Both results are scaled by a right shift and rounded to nearest, with exact halves going to the even value. A one-bit side flag, normally the frame-start marker, travels through the same pipeline and leaves aligned with the results it arrived with.

The pipeline moves only on enabled clocks, so the latency is counted in enable pulses rather than clocks. The `en` pin is the only flow control. There is no back-pressure: whatever consumes the outputs must take a new result on every enabled clock. The `CKPCE` parameter trades multipliers for input rate. A setting of 1 builds three real multipliers and accepts a sample on every clock. A setting of 2 builds two multipliers and requires one clock with `en` low between pulses. A setting of 3 builds one multiplier and requires two such clocks. The shared forms do their extra products during those idle clocks.

A complex word carries the real part in its upper half and the imaginary part in its lower half. Both parts are two's complement. A twiddle of unit magnitude is represented as 2^(CW-2).

Top module: `dif_butterfly`

## Requirements
- R1: `out_sum` holds (a + b) for each component, real in the upper OW bits and imaginary in the lower OW bits, computed at IW+1 bits and then right-shifted by SHIFT with round-half-to-even.
- R2: `out_prod` holds the complex product (a - b) * coef, divided by 2^(CW-2+SHIFT) with round-half-to-even, packed real-upper / imaginary-lower like the inputs.
- R3: A sample captured on an enabled clock edge reaches the outputs on the third enabled edge after it. The outputs change on no other edge.
- R4: `out_aux` carries `in_aux` with exactly the data latency of R3. The synchronous reset `rst` clears the flag pipeline, so `out_aux` is 0 after reset until a captured 1 has travelled through.
- R5: With CKPCE = 1 the product uses three real multipliers and `en` may stay high on every clock.
- R6: With CKPCE = 2 the product uses two multipliers. At least one clock with `en` low separates enabled clocks. The results are bit-identical to R1 and R2.
- R7: With CKPCE = 3 the product uses one multiplier. At least two clocks with `en` low separate enabled clocks. The results are bit-identical to R1 and R2.
- R8: A value exactly halfway between two output steps rounds to the even neighbour, for positive and for negative values: +0.5 gives 0, +1.5 gives 2, -0.5 gives 0, -1.5 gives -2.
- R9: A rounded result that does not fit in OW bits wraps modulo 2^OW. It is not saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag pipeline and spacing tracker |
| en | input | 1 | Clock enable; a high level accepts a sample and advances the pipeline |
| in_aux | input | 1 | Side flag sampled with the data |
| in_a | input | 2*IW | First complex sample {re, im} |
| in_b | input | 2*IW | Second complex sample {re, im} |
| in_coef | input | 2*CW | Twiddle factor {re, im}, unit = 2^(CW-2) |
| out_sum | output | 2*OW | Rounded a + b {re, im} |
| out_prod | output | 2*OW | Rounded (a - b) * coef {re, im} |
| out_aux | output | 1 | Side flag aligned with the outputs |

## Verification
The bench runs all three multiplier-sharing settings side by side at their tightest legal enable spacing, with random extra gaps. A mistake in the order of the shared products, or in which idle clock latches them, therefore shows up as wrong products only in the two- and one-multiplier builds. Exact-half cases in both signs catch rounding that goes away from zero or truncates, which would give ±1 or -1 where 0 or -2 is expected. A twiddle that pushes the product beyond OW bits exposes saturation logic, which would clamp where the model wraps. A reset in the middle of a stream, followed by stale data still in the pipe, catches a flag that is not cleared or that drifts one enable away from its results.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Count of enabled clocks that the complex product takes (operand
  // stage plus combine stage). The sum path is delayed by the same.
  localparam int CMUL_LAT = 2;

  // Idle-clock counter used to sequence the shared multipliers.
  typedef logic [1:0] gap_t;
  localparam gap_t GAP_SAT = 2'd3;

  // Round-half-to-even increment decision.
  function automatic logic tie_even_up(input logic lsb, input logic guard,
                                       input logic sticky);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/bfly_round.sv
module bfly_round #(
  parameter int IN_W  = 17,
  parameter int OUT_W = 17,
  parameter int DROP  = 0
) (
  input  logic signed [IN_W-1:0] din,
  output logic        [OUT_W-1:0] dout
);
  import bfly_pkg::*;

  localparam int NEED  = OUT_W + DROP;
  localparam int EXT_W = (IN_W > NEED) ? IN_W : NEED;

  logic signed [EXT_W-1:0] ext;
  logic [OUT_W-1:0] keep;

  assign ext  = EXT_W'(din);
  assign keep = ext[NEED-1:DROP];

  // Bits above the kept window are dropped: the result wraps (R9).
  if (EXT_W > NEED) begin : g_sink
    logic unused_hi;
    assign unused_hi = ^ext[EXT_W-1:NEED];
  end

  if (DROP == 0) begin : g_pass
    assign dout = keep;
  end else begin : g_rnd
    logic guard, sticky, up;
    assign guard = ext[DROP-1];
    if (DROP > 1) begin : g_st
      assign sticky = |ext[DROP-2:0];
    end else begin : g_nost
      assign sticky = 1'b0;
    end
    assign up   = tie_even_up(keep[0], guard, sticky);
    assign dout = keep + OUT_W'(up);

    // Exact halves must land on an even output step.
    always_comb begin
      if (!$isunknown(din) && guard && !sticky)
        p_tie_even_r8: assert (dout[0] == 1'b0);
    end
  end

endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int DW    = 17,
  parameter int CW    = 20,
  parameter int CKPCE = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DW-1:0]     d_re,
  input  logic signed [DW-1:0]     d_im,
  input  logic signed [CW-1:0]     c_re,
  input  logic signed [CW-1:0]     c_im,
  output logic signed [DW+CW+2:0]  p_re,
  output logic signed [DW+CW+2:0]  p_im
);
  import bfly_pkg::*;

  localparam int AW = CW + 1;
  localparam int BW = DW + 1;
  localparam int PW = AW + BW;
  localparam int RW = PW + 1;
  localparam gap_t GAP_MIN = gap_t'(CKPCE);

  function automatic logic signed [PW-1:0] mul(input logic signed [AW-1:0] x,
                                               input logic signed [BW-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  // Clocks since the last enable, saturating; sequences shared multipliers.
  gap_t gap;
  always_ff @(posedge clk) begin
    if (rst)                gap <= GAP_SAT;
    else if (en)            gap <= 2'd1;
    else if (gap != GAP_SAT) gap <= gap + 2'd1;
  end

  // Spacing rule per setting (R5, R6 and R7).
  p_enable_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    en |-> (gap >= GAP_MIN));

  // Operand stage: pre-adds for the three-product form.
  logic signed [BW-1:0] sdd;
  logic signed [AW-1:0] scc, dcc;
  logic signed [DW-1:0] od_re, od_im;
  logic signed [CW-1:0] oc_re;
  always_ff @(posedge clk) begin
    if (en) begin
      sdd   <= BW'(d_re) + BW'(d_im);
      scc   <= AW'(c_re) + AW'(c_im);
      dcc   <= AW'(c_im) - AW'(c_re);
      od_re <= d_re;
      od_im <= d_im;
      oc_re <= c_re;
    end
  end

  // k1 = cr*(dr+di), k2 = di*(cr+ci), k3 = dr*(ci-cr)
  logic signed [AW-1:0] k1a, k2a, k3a;
  logic signed [BW-1:0] k1b, k2b, k3b;
  assign k1a = AW'(oc_re);
  assign k1b = sdd;
  assign k2a = scc;
  assign k2b = BW'(od_im);
  assign k3a = dcc;
  assign k3b = BW'(od_re);

  if (CKPCE == 1) begin : g_three
    logic signed [PW-1:0] m1, m2, m3;
    assign m1 = mul(k1a, k1b);
    assign m2 = mul(k2a, k2b);
    assign m3 = mul(k3a, k3b);
    always_ff @(posedge clk) begin
      if (en) begin
        p_re <= RW'(m1) - RW'(m2);
        p_im <= RW'(m1) + RW'(m3);
      end
    end
  end else if (CKPCE == 2) begin : g_two
    logic signed [AW-1:0] xa;
    logic signed [BW-1:0] xb;
    logic signed [PW-1:0] mx, my, k1r, k2r;
    assign xa = en ? k3a : k1a;
    assign xb = en ? k3b : k1b;
    assign mx = mul(xa, xb);
    assign my = mul(k2a, k2b);
    always_ff @(posedge clk) begin
      if (en) begin
        p_re <= RW'(k1r) - RW'(k2r);
        p_im <= RW'(k1r) + RW'(mx);
      end else if (gap == 2'd1) begin
        k1r <= mx;
        k2r <= my;
      end
    end
  end else begin : g_one
    logic signed [AW-1:0] sa;
    logic signed [BW-1:0] sb;
    logic signed [PW-1:0] m, k1r, k2r;
    always_comb begin
      if (en)              begin sa = k3a; sb = k3b; end
      else if (gap == 2'd1) begin sa = k1a; sb = k1b; end
      else                 begin sa = k2a; sb = k2b; end
    end
    assign m = mul(sa, sb);
    always_ff @(posedge clk) begin
      if (en) begin
        p_re <= RW'(k1r) - RW'(k2r);
        p_im <= RW'(k1r) + RW'(m);
      end else if (gap == 2'd1) begin
        k1r <= m;
      end else if (gap == 2'd2) begin
        k2r <= m;
      end
    end
  end

endmodule

// File: rtl/dif_butterfly.sv
module dif_butterfly #(
  parameter int IW    = 16,
  parameter int CW    = 20,
  parameter int OW    = IW + 1,
  parameter int SHIFT = 0,
  parameter int CKPCE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_aux,
  input  logic [2*IW-1:0]   in_a,
  input  logic [2*IW-1:0]   in_b,
  input  logic [2*CW-1:0]   in_coef,
  output logic [2*OW-1:0]   out_sum,
  output logic [2*OW-1:0]   out_prod,
  output logic              out_aux
);
  import bfly_pkg::*;

  localparam int DW      = IW + 1;
  localparam int RW      = DW + CW + 3;
  localparam int SUM_DLY = CMUL_LAT;
  localparam int AUX_LEN = 1 + CMUL_LAT;

  logic signed [IW-1:0] a_re, a_im, b_re, b_im;
  assign a_re = in_a[2*IW-1:IW];
  assign a_im = in_a[IW-1:0];
  assign b_re = in_b[2*IW-1:IW];
  assign b_im = in_b[IW-1:0];

  // Stage 1: sum and difference grow one bit; twiddle registered alongside.
  logic signed [DW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [CW-1:0] cf_re, cf_im;
  always_ff @(posedge clk) begin
    if (en) begin
      sum_re <= DW'(a_re) + DW'(b_re);
      sum_im <= DW'(a_im) + DW'(b_im);
      dif_re <= DW'(a_re) - DW'(b_re);
      dif_im <= DW'(a_im) - DW'(b_im);
      cf_re  <= in_coef[2*CW-1:CW];
      cf_im  <= in_coef[CW-1:0];
    end
  end

  // Sum path held back to match the product latency.
  logic signed [DW-1:0] sre_d [SUM_DLY];
  logic signed [DW-1:0] sim_d [SUM_DLY];
  always_ff @(posedge clk) begin
    if (en) begin
      sre_d[0] <= sum_re;
      sim_d[0] <= sum_im;
      for (int k = 1; k < SUM_DLY; k++) begin
        sre_d[k] <= sre_d[k-1];
        sim_d[k] <= sim_d[k-1];
      end
    end
  end

  logic signed [RW-1:0] p_re, p_im;
  bfly_cmul #(.DW(DW), .CW(CW), .CKPCE(CKPCE)) u_cmul (
    .clk(clk), .rst(rst), .en(en),
    .d_re(dif_re), .d_im(dif_im), .c_re(cf_re), .c_im(cf_im),
    .p_re(p_re), .p_im(p_im)
  );

  // Index 0 = real, 1 = imaginary.
  logic signed [DW-1:0] s_fin [2];
  logic signed [RW-1:0] p_fin [2];
  logic [OW-1:0] s_rnd [2];
  logic [OW-1:0] p_rnd [2];
  assign s_fin[0] = sre_d[SUM_DLY-1];
  assign s_fin[1] = sim_d[SUM_DLY-1];
  assign p_fin[0] = p_re;
  assign p_fin[1] = p_im;

  for (genvar i = 0; i < 2; i++) begin : g_round
    bfly_round #(.IN_W(DW), .OUT_W(OW), .DROP(SHIFT)) u_rs (
      .din(s_fin[i]), .dout(s_rnd[i]));
    bfly_round #(.IN_W(RW), .OUT_W(OW), .DROP(CW - 2 + SHIFT)) u_rp (
      .din(p_fin[i]), .dout(p_rnd[i]));
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_sum  <= {s_rnd[0], s_rnd[1]};
      out_prod <= {p_rnd[0], p_rnd[1]};
    end
  end

  // Flag pipeline: reset, same enable-count latency as data.
  logic [AUX_LEN-1:0] aux_sr;
  always_ff @(posedge clk) begin
    if (rst) begin
      aux_sr  <= '0;
      out_aux <= 1'b0;
    end else if (en) begin
      aux_sr  <= {aux_sr[AUX_LEN-2:0], in_aux};
      out_aux <= aux_sr[AUX_LEN-1];
    end
  end

  p_aux_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_aux);

  p_aux_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_aux));

endmodule

// File: tb/dif_butterfly_test.sv
module dif_butterfly_test;

  localparam int IW = 16;
  localparam int CW = 20;
  localparam int OW = IW + 1;
  localparam int NDUT = 3;
  localparam int NDIR = 8;
  localparam int NCYC = 2600;
  localparam longint U = 64'sd1 <<< (CW - 2);

  typedef struct packed {
    logic [2*OW-1:0] s;
    logic [2*OW-1:0] p;
    logic            x;
    logic [1:0]      kind;   // 0: R2, 1: R8, 2: R9
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  logic en [NDUT];
  logic aux_i [NDUT];
  logic [2*IW-1:0] ina [NDUT];
  logic [2*IW-1:0] inb [NDUT];
  logic [2*CW-1:0] inc [NDUT];
  logic [2*OW-1:0] os [NDUT];
  logic [2*OW-1:0] op [NDUT];
  logic oa [NDUT];

  always #2.5ns clk = ~clk;

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(g == 2 ? 1 : 0),
                    .CKPCE(g + 1)) uut (
      .clk(clk), .rst(rst), .en(en[g]), .in_aux(aux_i[g]),
      .in_a(ina[g]), .in_b(inb[g]), .in_coef(inc[g]),
      .out_sum(os[g]), .out_prod(op[g]), .out_aux(oa[g]));
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t hq [NDUT][$];
  exp_t cur [NDUT];
  bit have [NDUT];
  int gap [NDUT];
  int nsent [NDUT];

  function automatic string cfg_tag(int g);
    return (g == 0) ? "R5" : (g == 1) ? "R6" : "R7";
  endfunction

  function automatic logic [OW-1:0] rnd(longint v, int d);
    longint q, r, h;
    if (d == 0) return v[OW-1:0];
    q = v >>> d;
    r = v - (q <<< d);
    h = 64'sd1 <<< (d - 1);
    if (r > h || (r == h && q[0])) q = q + 1;
    return q[OW-1:0];
  endfunction

  function automatic exp_t model(int g, logic [2*IW-1:0] a, logic [2*IW-1:0] b,
                                 logic [2*CW-1:0] c, logic x, logic [1:0] kind);
    exp_t m;
    longint ar, ai, br, bi, cr, ci, dr, di, pr, pi;
    int sh;
    sh = (g == 2) ? 1 : 0;
    ar = longint'($signed(a[2*IW-1:IW]));
    ai = longint'($signed(a[IW-1:0]));
    br = longint'($signed(b[2*IW-1:IW]));
    bi = longint'($signed(b[IW-1:0]));
    cr = longint'($signed(c[2*CW-1:CW]));
    ci = longint'($signed(c[CW-1:0]));
    dr = ar - br;
    di = ai - bi;
    pr = dr * cr - di * ci;
    pi = dr * ci + di * cr;
    m.s = {rnd(ar + br, sh), rnd(ai + bi, sh)};
    m.p = {rnd(pr, CW - 2 + sh), rnd(pi, CW - 2 + sh)};
    m.x = x;
    m.kind = kind;
    return m;
  endfunction

  task automatic pick(input int n, output logic [2*IW-1:0] a,
                      output logic [2*IW-1:0] b, output logic [2*CW-1:0] c,
                      output logic [1:0] kind);
    longint h;
    h = U >>> 1;
    b = '0;
    kind = 2'd0;
    case (n)
      0: begin a = {16'sd1, 16'sd0};  c = {CW'(h), CW'(0)}; kind = 2'd1; end
      1: begin a = {16'sd3, 16'sd0};  c = {CW'(h), CW'(0)}; kind = 2'd1; end
      2: begin a = {-16'sd1, 16'sd0}; c = {CW'(h), CW'(0)}; kind = 2'd1; end
      3: begin a = {-16'sd3, 16'sd0}; c = {CW'(h), CW'(0)}; kind = 2'd1; end
      4: begin a = {16'sd5, 16'sd7}; b = {-16'sd2, 16'sd1}; c = {CW'(U), CW'(0)}; end
      5: begin a = {16'sd32767, 16'sd32767}; b = {16'h8000, 16'h8000};
               c = {CW'(0), CW'(U)}; end
      6: begin a = {16'sd32767, 16'sd32767}; b = {16'h8000, 16'h8000};
               c = {CW'(U), CW'(U)}; kind = 2'd2; end
      7: begin a = {16'h8000, 16'h8000}; b = {16'sd32767, 16'sd32767};
               c = {CW'(-U), CW'(0)}; end
      default: begin
        a = {$urandom, $urandom} & {2*IW{1'b1}};
        b = {$urandom, $urandom} & {2*IW{1'b1}};
        c = {CW'($urandom), CW'($urandom)};
      end
    endcase
  endtask

  task automatic check_all();
    for (int g = 0; g < NDUT; g++) begin
      n_chk++;
      if (oa[g] !== cur[g].x) begin
        n_bad++;
        $display("FAIL R4 %s dut%0d out_aux actual=%b expected=%b",
                 cfg_tag(g), g, oa[g], cur[g].x);
      end
      if (have[g]) begin
        n_chk++;
        if (os[g] !== cur[g].s) begin
          n_bad++;
          $display("FAIL R1 R3 %s dut%0d out_sum actual=%h expected=%h",
                   cfg_tag(g), g, os[g], cur[g].s);
        end
        n_chk++;
        if (op[g] !== cur[g].p) begin
          n_bad++;
          $display("FAIL %s R3 %s dut%0d out_prod actual=%h expected=%h",
                   cur[g].kind == 2'd1 ? "R8" : cur[g].kind == 2'd2 ? "R9" : "R2",
                   cfg_tag(g), g, op[g], cur[g].p);
        end
      end
    end
  endtask

  task automatic clear_model();
    for (int g = 0; g < NDUT; g++) begin
      hq[g].delete();
      cur[g] = '0;
      have[g] = 1'b0;
      gap[g] = 99;
      en[g] = 1'b0;
    end
  endtask

  initial begin
    logic [2*IW-1:0] a, b;
    logic [2*CW-1:0] c;
    logic [1:0] kind;
    logic x;
    rst = 1'b1;
    for (int g = 0; g < NDUT; g++) begin
      aux_i[g] = 1'b0; ina[g] = '0; inb[g] = '0; inc[g] = '0; nsent[g] = 0;
    end
    clear_model();
    repeat (4) @(negedge clk);
    check_all();   // reset state: out_aux low (R4)
    rst = 1'b0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (cyc >= 1300 && cyc < 1303) begin
        rst = 1'b1;   // mid-stream reset: flag pipe must clear (R4)
        clear_model();
      end else begin
        rst = 1'b0;
        for (int g = 0; g < NDUT; g++) begin
          // CKPCE = g+1 needs g idle clocks between enables (R5, R6, R7)
          en[g] = (gap[g] >= g) && (nsent[g] < NDIR || ($urandom % 4) != 0);
          if (en[g]) begin
            pick(nsent[g], a, b, c, kind);
            x = (nsent[g] % 5 == 0) || ($urandom % 7 == 0);
            ina[g] = a; inb[g] = b; inc[g] = c; aux_i[g] = x;
            hq[g].push_back(model(g, a, b, c, x, kind));
            if (hq[g].size() > 3) begin
              cur[g] = hq[g].pop_front();
              have[g] = 1'b1;
            end
            nsent[g]++;
            gap[g] = 0;
          end else begin
            ina[g] = {$urandom, $urandom} & {2*IW{1'b1}};
            gap[g]++;
          end
        end
      end
      @(negedge clk);
      check_all();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=run complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule